// File: doc/BRIEF.md
# Serial Character Transmitter with Drain-on-Disable

This block turns parallel characters from a CPU into an asynchronous serial stream on a single line. The CPU writes a character into a one-entry holding stage. When the serializer is free, the block moves that character into the serializer, which sends a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two stop bits. An external one-cycle strobe marks each bit boundary, so the block itself has no baud divider. Character length, parity kind and stop length are static inputs. The host changes them only while the transmitter is fully empty.

Command strobes enable and disable CPU writes. A disable command does not cut off traffic. Whatever is already in the holding stage and the serializer still goes out, and only new writes are refused. The block raises an interrupt request, if its mask input allows it, only when both the holding stage and the serializer are empty. Two status outputs report these two empty conditions separately.

Top module: `uart_tx_drain`

## Requirements
- R1: After reset, `tx_o` is 1, `thr_empty_o` is 1, `tx_empty_o` is 1 and CPU writes are refused until an enable command arrives. Whenever the serializer holds no character, `tx_o` stays at 1.
- R2: A character starts with exactly one bit period of 0 on `tx_o`. A bit period is the interval between two `tick_i` pulses. `tx_o` changes only in the cycle after a clock edge that sampled `tick_i` high.
- R3: Data bits follow the start bit, least significant bit first. The count is 5 + `len_sel_i` (00 = 5 bits, 11 = 8 bits). With 8 bits, no parity and one stop bit, the value 0x5D is sent as 1,0,1,1,1,0,1,0.
- R4: `par_sel_i` = 01 appends an even-parity bit and 10 appends an odd-parity bit, each right after the most significant data bit. The parity bit makes the count of ones over data plus parity even or odd, respectively. 00 and 11 send no parity bit.
- R5: The frame ends with one stop bit at 1 when `stop2_i` is 0, and with two stop bits when `stop2_i` is 1.
- R6: A held character moves to the serializer only at a tick, and only when the serializer is idle or its last stop bit is ending. Queued characters therefore follow each other with no idle bit between them.
- R7: A write is accepted when writes are enabled and the holding stage is either empty or handing its character to the serializer in that same cycle. A write into a full holding stage that is not handing over is ignored.
- R8: A disable command blocks writes from its own cycle on, including a write in that same cycle. Characters already queued are still transmitted in order until both stages are empty.
- R9: An enable command allows writes from its own cycle on. It has no effect on a character being shifted. When enable and disable arrive together, disable wins.
- R10: `irq_o` equals `irq_mask_i` AND holding stage empty AND serializer empty. An accepted write drops it in the next cycle.
- R11: `thr_empty_o` is 1 exactly when the holding stage is empty. `tx_empty_o` is 1 exactly when both the holding stage and the serializer are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle bit-boundary strobe |
| wr_i | input | 1 | CPU write strobe for the holding stage |
| wr_data_i | input | MAX_BITS | Character to send |
| cmd_en_i | input | 1 | Enable-writes command strobe |
| cmd_dis_i | input | 1 | Disable-writes command strobe |
| irq_mask_i | input | 1 | Interrupt request mask, 1 = allowed |
| len_sel_i | input | LEN_W | Data length select, bits = 5 + value |
| par_sel_i | input | 2 | Parity select: 01 even, 10 odd, else none |
| stop2_i | input | 1 | 1 = two stop bits |
| tx_o | output | 1 | Serial output, 1 when idle |
| thr_empty_o | output | 1 | Holding stage empty |
| tx_empty_o | output | 1 | Holding stage and serializer both empty |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle here. The first pair is a CPU write and the handover of the held character to the serializer at the tick that ends a stop bit. The second pair is a CPU write and a disable command. The bench waits for the cycle in which its own serial decoder has just sampled the last stop bit while `tick_i` is high and the holding stage is full, and it writes a third character then. That write must land, and all three characters must arrive in order with no gap. The bench also drives a write together with a disable command. It judges the result by `thr_empty_o` staying 1 and by no frame at all appearing on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_e;

  localparam int unsigned STOP_MAX = 2;

  function automatic logic par_enabled(input par_mode_e m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction
endpackage

// File: rtl/uart_tx_cmd.sv
module uart_tx_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_en_i,
  input  logic cmd_dis_i,
  output logic wr_ok_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (cmd_dis_i) en_q <= 1'b0;
    else if (cmd_en_i)  en_q <= 1'b1;
  end

  // commands act in their own cycle; disable has priority
  assign wr_ok_o = ~cmd_dis_i & (en_q | cmd_en_i);

  AST_DIS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_dis_i |=> (!wr_ok_o || cmd_en_i)); // R8
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned MAX_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [MAX_BITS-1:0] wr_data_i,
  input  logic                wr_ok_i,
  input  logic                take_i,
  output logic                valid_o,
  output logic [MAX_BITS-1:0] data_o
);
  logic                valid_q;
  logic [MAX_BITS-1:0] data_q;
  logic                accept;

  // a write may refill the stage in the cycle it is handed over
  assign accept = wr_i & wr_ok_i & (~valid_q | take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= wr_data_i;
    end else if (take_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_TAKE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> valid_q); // R6
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !take_i) |=> (valid_q && $stable(data_q))); // R7
  AST_IGNORED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ok_i && !take_i) |=> ($stable(valid_q) && $stable(data_q))); // R8
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 8,
  parameter int unsigned MIN_BITS = 5,
  parameter int unsigned LEN_W    = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                hold_valid_i,
  input  logic [MAX_BITS-1:0] hold_data_i,
  input  logic [LEN_W-1:0]    len_sel_i,
  input  logic [1:0]          par_sel_i,
  input  logic                stop2_i,
  output logic                take_o,
  output logic                busy_o,
  output logic                tx_o
);
  localparam int unsigned FRAME_W = MAX_BITS + 1 + STOP_MAX;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  par_mode_e           par_mode;
  logic                par_on;
  logic [CNT_W-1:0]    nbits;
  logic [CNT_W-1:0]    total;
  logic [MAX_BITS-1:0] data_m;
  logic                par_bit;
  logic [FRAME_W-1:0]  frame_d;

  logic                busy_q;
  logic                tx_q;
  logic [FRAME_W-1:0]  sh_q;
  logic [CNT_W-1:0]    rem_q;
  logic                boundary;

  assign par_mode = par_mode_e'(par_sel_i);
  assign par_on   = par_enabled(par_mode);
  assign nbits    = CNT_W'(MIN_BITS) + CNT_W'(len_sel_i);
  assign total    = nbits + CNT_W'(par_on) + (stop2_i ? CNT_W'(2) : CNT_W'(1));

  for (genvar gi = 0; gi < MAX_BITS; gi++) begin : g_mask
    assign data_m[gi] = (CNT_W'(gi) < nbits) ? hold_data_i[gi] : 1'b0;
  end

  assign par_bit = (^data_m) ^ (par_mode == PAR_ODD);

  // frame without start bit: data, optional parity, then stop marks
  for (genvar gi = 0; gi < FRAME_W; gi++) begin : g_frame
    if (gi < MAX_BITS) begin : g_dat
      assign frame_d[gi] = (CNT_W'(gi) < nbits) ? hold_data_i[gi] :
                           ((CNT_W'(gi) == nbits) && par_on) ? par_bit : 1'b1;
    end else begin : g_tail
      assign frame_d[gi] = ((CNT_W'(gi) == nbits) && par_on) ? par_bit : 1'b1;
    end
  end

  assign boundary = tick_i & (~busy_q | (rem_q == '0));
  assign take_o   = boundary & hold_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
      sh_q   <= '1;
      rem_q  <= '0;
    end else if (boundary) begin
      if (hold_valid_i) begin
        busy_q <= 1'b1;
        tx_q   <= 1'b0;
        sh_q   <= frame_d;
        rem_q  <= total;
      end else begin
        busy_q <= 1'b0;
        tx_q   <= 1'b1;
      end
    end else if (tick_i) begin
      tx_q  <= sh_q[0];
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      rem_q <= rem_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = tx_q;

  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tx_q); // R1
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (!tx_q && busy_q)); // R2
  AST_TX_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tx_q)); // R2
  AST_LAST_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rem_q == '0) |-> tx_q); // R5
endmodule

// File: rtl/uart_tx_drain.sv
module uart_tx_drain #(
  parameter int unsigned MAX_BITS = 8,
  parameter int unsigned MIN_BITS = 5,
  parameter int unsigned LEN_W    = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_i,
  input  logic [MAX_BITS-1:0] wr_data_i,
  input  logic                cmd_en_i,
  input  logic                cmd_dis_i,
  input  logic                irq_mask_i,
  input  logic [LEN_W-1:0]    len_sel_i,
  input  logic [1:0]          par_sel_i,
  input  logic                stop2_i,
  output logic                tx_o,
  output logic                thr_empty_o,
  output logic                tx_empty_o,
  output logic                irq_o
);
  logic                wr_ok;
  logic                take;
  logic                hold_valid;
  logic [MAX_BITS-1:0] hold_data;
  logic                busy;

  uart_tx_cmd u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_en_i  (cmd_en_i),
    .cmd_dis_i (cmd_dis_i),
    .wr_ok_o   (wr_ok)
  );

  uart_tx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .wr_ok_i   (wr_ok),
    .take_i    (take),
    .valid_o   (hold_valid),
    .data_o    (hold_data)
  );

  uart_tx_shift #(
    .MAX_BITS (MAX_BITS),
    .MIN_BITS (MIN_BITS),
    .LEN_W    (LEN_W)
  ) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .hold_valid_i (hold_valid),
    .hold_data_i  (hold_data),
    .len_sel_i    (len_sel_i),
    .par_sel_i    (par_sel_i),
    .stop2_i      (stop2_i),
    .take_o       (take),
    .busy_o       (busy),
    .tx_o         (tx_o)
  );

  assign thr_empty_o = ~hold_valid;
  assign tx_empty_o  = ~hold_valid & ~busy;
  assign irq_o       = irq_mask_i & tx_empty_o;

  AST_IRQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (thr_empty_o && tx_empty_o && irq_mask_i)); // R10
  AST_EMPTY_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (thr_empty_o && tx_o)); // R11
endmodule

// File: tb/uart_tx_drain_tb.sv
module uart_tx_drain_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i;
  logic       wr_i;
  logic [7:0] wr_data_i;
  logic       cmd_en_i, cmd_dis_i, irq_mask_i;
  logic [1:0] len_sel_i, par_sel_i;
  logic       stop2_i;
  logic       tx_o, thr_empty_o, tx_empty_o, irq_o;

  always #4 clk_i = ~clk_i;

  uart_tx_drain dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .cmd_en_i(cmd_en_i), .cmd_dis_i(cmd_dis_i),
    .irq_mask_i(irq_mask_i), .len_sel_i(len_sel_i), .par_sel_i(par_sel_i),
    .stop2_i(stop2_i), .tx_o(tx_o), .thr_empty_o(thr_empty_o),
    .tx_empty_o(tx_empty_o), .irq_o(irq_o)
  );

  int n_vec = 0, n_bad = 0;
  bit ended = 0;
  logic [7:0] exp_q[$];

  // decoder state
  int dstate = 0, dcnt = 0, rx_cnt = 0, idle_run = 0, last_gap = -1;
  logic [7:0] ddata, last_rx;
  logic dpar;
  bit frame_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  function automatic int nbits_f();
    return 5 + int'(len_sel_i);
  endfunction

  function automatic logic [7:0] mask_f(input logic [7:0] d);
    return d & 8'((1 << nbits_f()) - 1);
  endfunction

  function automatic logic exp_par_f(input logic [7:0] d);
    return (^mask_f(d)) ^ (par_sel_i == 2'b10);
  endfunction

  function automatic bit par_on_f();
    return (par_sel_i == 2'b01) || (par_sel_i == 2'b10);
  endfunction

  task automatic sample_bit();
    logic [7:0] e;
    case (dstate)
      0: if (tx_o == 1'b0) begin
           dstate = 1; dcnt = 0; ddata = '0; last_gap = idle_run; idle_run = 0;
         end else idle_run++;
      1: begin
           ddata[dcnt] = tx_o; dcnt++;
           if (dcnt == nbits_f()) begin dstate = par_on_f() ? 2 : 3; dcnt = 0; end
         end
      2: begin dpar = tx_o; dstate = 3; end
      default: begin
        chk(tx_o == 1'b1, "R5 stop bit level", int'(tx_o), 1);
        dcnt++;
        if (dcnt == (stop2_i ? 2 : 1)) begin
          dstate = 0; frame_done = 1; rx_cnt++; last_rx = ddata;
          if (exp_q.size() == 0) chk(1'b0, "R8 unexpected frame", int'(ddata), 0);
          else begin
            e = exp_q.pop_front();
            chk(ddata == mask_f(e), "R3 data bits", int'(ddata), int'(mask_f(e)));
            if (par_on_f()) chk(dpar == exp_par_f(e), "R4 parity bit", int'(dpar), int'(exp_par_f(e)));
          end
        end
      end
    endcase
  endtask

  // bit strobe every 4 cycles; line sampled just before each strobe
  initial begin
    int div = 0;
    tick_i = 1'b0;
    forever begin
      @(negedge clk_i);
      frame_done = 0;
      if (rst_ni && div == 3) sample_bit();
      tick_i = (div == 3);
      div = (div + 1) % 4;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic write(input logic [7:0] d, input bit acc);
    step();
    wr_i = 1'b1; wr_data_i = d;
    if (acc) exp_q.push_back(d);
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic cmd(input bit en, input bit dis);
    step();
    cmd_en_i = en; cmd_dis_i = dis;
    @(posedge clk_i); #1;
    cmd_en_i = 1'b0; cmd_dis_i = 1'b0;
  endtask

  task automatic wait_thr();
    do step(); while (!thr_empty_o);
  endtask

  task automatic drain();
    do step(); while (!(exp_q.size() == 0 && tx_empty_o && dstate == 0));
    repeat (8) step();
  endtask

  initial begin
    int base;
    void'($urandom(32'h1A2B));
    rst_ni = 1'b0; wr_i = 0; wr_data_i = '0; cmd_en_i = 0; cmd_dis_i = 0;
    irq_mask_i = 1; len_sel_i = 2'b11; par_sel_i = 2'b00; stop2_i = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    chk(tx_o == 1, "R1 reset tx", int'(tx_o), 1);
    chk(thr_empty_o == 1, "R11 reset thr_empty", int'(thr_empty_o), 1);
    chk(tx_empty_o == 1, "R11 reset tx_empty", int'(tx_empty_o), 1);
    chk(irq_o == 1, "R10 reset irq", int'(irq_o), 1);

    // R1: writes refused before enable
    write(8'hAA, 0);
    step();
    chk(thr_empty_o == 1, "R1 write before enable", int'(thr_empty_o), 1);

    cmd(1, 0);
    // R3 0x5D in 8N1
    write(8'h5D, 1);
    chk(irq_o == 0, "R10 irq drops on write", int'(irq_o), 0);
    chk(thr_empty_o == 0, "R11 thr full", int'(thr_empty_o), 0);
    irq_mask_i = 0;
    step();
    chk(irq_o == 0, "R10 masked", int'(irq_o), 0);
    irq_mask_i = 1;
    drain();
    chk(last_rx == 8'h5D, "R3 0x5D pattern", int'(last_rx), 8'h5D);
    chk(irq_o == 1, "R10 irq after drain", int'(irq_o), 1);

    // R6 back-to-back with no gap
    write(8'h31, 1); wait_thr(); write(8'hC4, 1);
    chk(tx_empty_o == 0, "R11 tx_empty while busy", int'(tx_empty_o), 0);
    drain();
    chk(last_gap == 0, "R6 no idle gap", last_gap, 0);

    // R7 write into full stage away from a handover is ignored
    base = rx_cnt;
    write(8'h11, 1); wait_thr(); write(8'h22, 1);
    do step(); while (tick_i);
    wr_i = 1; wr_data_i = 8'h33;
    @(posedge clk_i); #1 wr_i = 0;
    chk(thr_empty_o == 0, "R7 full stage kept", int'(thr_empty_o), 0);
    drain();
    chk(rx_cnt - base == 2, "R7 ignored write frames", rx_cnt - base, 2);

    // R7 write in the handover cycle
    base = rx_cnt;
    write(8'h44, 1); wait_thr(); write(8'h55, 1);
    do step(); while (!(tick_i && frame_done && !thr_empty_o));
    wr_i = 1; wr_data_i = 8'h66; exp_q.push_back(8'h66);
    @(posedge clk_i); #1 wr_i = 0;
    step();
    chk(thr_empty_o == 0, "R7 refill on handover", int'(thr_empty_o), 0);
    drain();
    chk(rx_cnt - base == 3, "R7 handover frames", rx_cnt - base, 3);
    chk(last_gap == 0, "R6 handover gap", last_gap, 0);

    // R8 write together with disable
    step();
    cmd_dis_i = 1; wr_i = 1; wr_data_i = 8'h77;
    @(posedge clk_i); #1 cmd_dis_i = 0; wr_i = 0;
    step();
    chk(thr_empty_o == 1, "R8 write with disable", int'(thr_empty_o), 1);
    repeat (40) step();
    chk(tx_o == 1 && dstate == 0, "R8 no frame after disable", int'(tx_o), 1);

    // R9 both commands: disable wins
    cmd(1, 1);
    write(8'h78, 0);
    step();
    chk(thr_empty_o == 1, "R9 disable wins", int'(thr_empty_o), 1);

    // R8/R9 drain then re-enable mid drain
    base = rx_cnt;
    cmd(1, 0);
    write(8'h81, 1); wait_thr(); write(8'h82, 1);
    cmd(0, 1);
    write(8'h83, 0);
    chk(thr_empty_o == 0, "R8 queued kept", int'(thr_empty_o), 0);
    chk(tx_empty_o == 0, "R8 still draining", int'(tx_empty_o), 0);
    cmd(1, 0);
    wait_thr();
    write(8'h84, 1);
    drain();
    chk(rx_cnt - base == 3, "R9 drain frames", rx_cnt - base, 3);

    // random formats
    for (int i = 0; i < 96; i++) begin
      if (i % 6 == 0) begin
        drain();
        len_sel_i = 2'($urandom_range(0, 3));
        par_sel_i = 2'($urandom_range(0, 3));
        stop2_i   = 1'($urandom_range(0, 1));
        irq_mask_i = 1'($urandom_range(0, 1));
        step();
        chk(irq_o == irq_mask_i, "R10 idle irq", int'(irq_o), int'(irq_mask_i));
      end
      wait_thr();
      write(8'($urandom()), 1);
      chk(irq_o == 0, "R10 irq low after write", int'(irq_o), 0);
    end
    drain();
    chk(exp_q.size() == 0, "R8 all frames delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule